// File: doc/BRIEF.md
# Bytecode Fetch and Dispatch Unit

This unit feeds a stack-machine execution state with byte-oriented instructions. It reads instruction memory one aligned 32-bit word at a time and packs the bytes into an eight-byte window that is indexed by a byte-granular program counter. It then decodes one bytecode per cycle over two registered stages. Each opcode is looked up in a 256-entry class table, which gives both its routing class and its total length of one to four bytes. A bytecode may start at any byte lane and may straddle a word boundary. In that case decode waits until every byte of the instruction is present.

The state is entered by a command that carries a condition result. When the condition holds, the unit saves the caller's program counter as the link, raises the state bit and starts fetching at the target. Only hardware-class bytecodes keep the unit running. An emulated or undefined opcode is dispatched with a handler address and ends the state in the same cycle. An interrupt ends the state at once and discards anything that has not yet been dispatched. Every exit records a restart address: the first byte of the oldest bytecode that was not dispatched. An interrupt taken in the state also sets a saved-state flag, so that a later return can resume at that restart address.

Top module: `bcd_dispatch_unit`

## Requirements
- R1: After reset the state bit, the saved-state flag and `disp_valid` are low and no fetch is requested.
- R2: When `enter_valid` is high with `enter_cond` high while the state bit is low, the state bit is high on the next cycle and `link_pc` equals the `native_pc` that was presented. When `enter_cond` is low, the state bit stays low and no fetch is issued.
- R3: Fetch requests occur only while the state bit is high. Each request is word aligned, and requests walk upward from the word that holds the entry target. At most one request is outstanding. Byte lane i of `imem_rdata` holds address word+i.
- R4: Bytecodes are dispatched in program order. `disp_pc` is the address of the opcode. The opcode's length is the class-table entry bits [1:0] plus one. `disp_operands` carries the following bytes, the first of them in bits [7:0], and zero in the unused lanes. This holds at unaligned entry points and across word boundaries.
- R5: An opcode whose class field (entry bits [3:2]) is 01 is dispatched with `disp_kind` 01 and `disp_target` 0. Execution then continues with the next bytecode.
- R6: An opcode whose class field is 10 is dispatched with `disp_kind` 10 and `disp_target` = `emu_base` + (opcode << `EMU_SHIFT`). In that same cycle the state bit is low and `exit_pc` equals `disp_pc`, which is the return point.
- R7: An opcode whose class field is 00 or 11 is dispatched with `disp_kind` 00 and `disp_target` = `UNDEF_VECTOR`. It leaves the state exactly as in R6. `disp_kind` 11 never occurs.
- R8: An interrupt while the state bit is high clears the state bit on the next cycle and suppresses any further dispatch. It sets `exit_pc` to the first byte of the oldest undispatched bytecode and sets `saved_bc_state`. An interrupt while the state bit is low clears `saved_bc_state`. Re-entering at `exit_pc` resumes the same stream.
- R9: Class-table writes take effect only while the state bit is low. Writes made while it is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Class-table write strobe |
| tbl_idx | input | 8 | Opcode whose entry is written |
| tbl_data | input | 4 | Entry: [3:2] class, [1:0] length minus one |
| enter_valid | input | 1 | Enter-state command |
| enter_cond | input | 1 | Condition result for the command |
| enter_target | input | 32 | First bytecode address |
| native_pc | input | 32 | Caller address saved as link |
| emu_base | input | 32 | Base of the emulation handler table |
| irq | input | 1 | Interrupt request |
| imem_req | output | 1 | Instruction word read request |
| imem_addr | output | 32 | Word-aligned read address |
| imem_rvalid | input | 1 | Read data valid, one per request |
| imem_rdata | input | 32 | Read data word |
| bc_state | output | 1 | Bytecode state bit |
| saved_bc_state | output | 1 | State bit saved at the last interrupt |
| link_pc | output | 32 | Saved caller address |
| exit_pc | output | 32 | Restart address of the last exit |
| disp_valid | output | 1 | Dispatch strobe |
| disp_kind | output | 2 | 01 hardware, 10 emulated, 00 undefined |
| disp_opcode | output | 8 | Dispatched opcode |
| disp_operands | output | 24 | Operand bytes |
| disp_pc | output | 32 | Address of the opcode |
| disp_target | output | 32 | Handler address (0 for hardware) |

## Verification
A long pseudo-random program is entered at random byte offsets. Mostly hardware opcodes of every length are mixed with rarer emulated and undefined ones. This separates errors in byte extraction and length from errors in routing. Interrupts arrive at random points and the bench resumes at the reported restart address, which exposes off-by-one restart points and stale fetch data after an exit. Directed cases cover an entry two bytes into a word with a four-byte instruction that straddles the word boundary, a table write attempted during the state, and a failed-condition entry.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int OP_W       = 8;
  localparam int WORD_BYTES = 4;
  localparam int OFS_W      = $clog2(WORD_BYTES);
  localparam int OPND_W     = (WORD_BYTES - 1) * 8;

  typedef enum logic [1:0] {
    K_UNDEF = 2'b00,
    K_HW    = 2'b01,
    K_EMU   = 2'b10
  } bc_kind_e;

  typedef struct packed {
    logic [1:0] cls;
    logic [1:0] len_m1;
  } tbl_entry_t;

  function automatic bc_kind_e cls_to_kind(input logic [1:0] cls);
    case (cls)
      2'b01:   return K_HW;
      2'b10:   return K_EMU;
      default: return K_UNDEF;
    endcase
  endfunction
endpackage

// File: rtl/bcd_class_table.sv
module bcd_class_table
  import bcd_pkg::*;
#(
  parameter int ENTRIES = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  tbl_entry_t                 wr_data,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output tbl_entry_t                 rd_data
);
  tbl_entry_t tab_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tab_q[i] <= '0;
    end else if (wr_en) begin
      tab_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = tab_q[rd_idx];
endmodule

// File: rtl/bcd_fetch_buf.sv
module bcd_fetch_buf
  import bcd_pkg::*;
#(
  parameter int BUF_BYTES = 8,
  localparam int BUF_W    = BUF_BYTES * 8,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      start_pc,
  input  logic             run,
  input  logic             abort,
  input  logic             consume,
  input  logic [2:0]       take_len,
  input  logic             rvalid,
  input  logic [31:0]      rdata,
  output logic             req,
  output logic [31:0]      addr,
  output logic [31:0]      head_pc,
  output logic [31:0]      window,
  output logic [CNT_W-1:0] count
);
  logic [BUF_W-1:0] buf_q, buf_d, word_ext;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      faddr_q, faddr_d, pc_q, pc_d;
  logic [OFS_W-1:0] skip_q, skip_d;
  logic             outst_q, outst_d, drop_q, drop_d;

  assign req     = run && !outst_q && (cnt_q <= CNT_W'(BUF_BYTES - WORD_BYTES));
  assign addr    = faddr_q;
  assign head_pc = pc_q;
  assign window  = buf_q[31:0];
  assign count   = cnt_q;

  always_comb begin
    buf_d    = buf_q;
    cnt_d    = cnt_q;
    faddr_d  = faddr_q;
    pc_d     = pc_q;
    skip_d   = skip_q;
    outst_d  = outst_q;
    drop_d   = drop_q;
    word_ext = BUF_W'(rdata >> {skip_q, 3'b000});
    if (consume) begin
      buf_d = buf_q >> {take_len, 3'b000};
      cnt_d = cnt_q - CNT_W'(take_len);
      pc_d  = pc_q + 32'(take_len);
    end
    if (rvalid) begin
      outst_d = 1'b0;
      if (drop_q) begin
        drop_d = 1'b0;
      end else if (run) begin
        buf_d  = buf_d | (word_ext << {cnt_d, 3'b000});
        cnt_d  = cnt_d + CNT_W'(WORD_BYTES) - CNT_W'(skip_q);
        skip_d = '0;
      end
    end
    if (req) begin
      faddr_d = faddr_q + 32'(WORD_BYTES);
      outst_d = 1'b1;
    end
    if (abort && outst_q && !rvalid) drop_d = 1'b1;
    if (start) begin
      buf_d   = '0;
      cnt_d   = '0;
      pc_d    = start_pc;
      faddr_d = {start_pc[31:OFS_W], {OFS_W{1'b0}}};
      skip_d  = start_pc[OFS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      faddr_q <= '0;
      pc_q    <= '0;
      skip_q  <= '0;
      outst_q <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      cnt_q   <= cnt_d;
      faddr_q <= faddr_d;
      pc_q    <= pc_d;
      skip_q  <= skip_d;
      outst_q <= outst_d;
      drop_q  <= drop_d;
    end
  end
endmodule

// File: rtl/bcd_decode.sv
module bcd_decode
  import bcd_pkg::*;
#(
  parameter int          EMU_SHIFT    = 4,
  parameter logic [31:0] UNDEF_VECTOR = 32'h0000_0100,
  parameter int          CNT_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              irq,
  input  logic [31:0]       window,
  input  logic [CNT_W-1:0]  count,
  input  logic [31:0]       head_pc,
  input  tbl_entry_t        entry,
  input  logic [31:0]       emu_base,
  output logic [OP_W-1:0]   look_op,
  output logic              consume,
  output logic [2:0]        take_len,
  output logic              exit_now,
  output logic [31:0]       restart_pc,
  output logic              disp_valid,
  output logic [1:0]        disp_kind,
  output logic [OP_W-1:0]   disp_opcode,
  output logic [OPND_W-1:0] disp_operands,
  output logic [31:0]       disp_pc,
  output logic [31:0]       disp_target
);
  // stage 1: opcode extraction and class lookup
  logic [OPND_W-1:0] opnd_s1;
  // stage 2 registers
  logic              d2_v_q;
  bc_kind_e          d2_kind_q;
  logic [OP_W-1:0]   d2_op_q;
  logic [OPND_W-1:0] d2_opnd_q;
  logic [31:0]       d2_pc_q;
  // dispatch registers
  logic              dv_q, dv_d;
  logic [1:0]        dk_q;
  logic [OP_W-1:0]   dop_q;
  logic [OPND_W-1:0] dopnd_q;
  logic [31:0]       dpc_q, dtgt_q, tgt_d;

  assign look_op  = window[OP_W-1:0];
  assign take_len = {1'b0, entry.len_m1} + 3'd1;
  assign exit_now = active && d2_v_q && (d2_kind_q != K_HW);
  assign consume  = active && !irq && !exit_now && (count != '0) &&
                    (count >= CNT_W'(take_len));
  assign restart_pc = d2_v_q ? d2_pc_q : head_pc;

  always_comb begin
    opnd_s1 = '0;
    for (int b = 1; b < WORD_BYTES; b++) begin
      if (b <= int'(entry.len_m1)) opnd_s1[(b-1)*8 +: 8] = window[b*8 +: 8];
    end
  end

  assign dv_d = active && d2_v_q && !irq;

  always_comb begin
    case (d2_kind_q)
      K_HW:    tgt_d = '0;
      K_EMU:   tgt_d = emu_base + (32'(d2_op_q) << EMU_SHIFT);
      default: tgt_d = UNDEF_VECTOR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d2_v_q    <= 1'b0;
      d2_kind_q <= K_UNDEF;
      d2_op_q   <= '0;
      d2_opnd_q <= '0;
      d2_pc_q   <= '0;
    end else begin
      d2_v_q <= consume;
      if (consume) begin
        d2_kind_q <= cls_to_kind(entry.cls);
        d2_op_q   <= look_op;
        d2_opnd_q <= opnd_s1;
        d2_pc_q   <= head_pc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q    <= 1'b0;
      dk_q    <= '0;
      dop_q   <= '0;
      dopnd_q <= '0;
      dpc_q   <= '0;
      dtgt_q  <= '0;
    end else begin
      dv_q <= dv_d;
      if (dv_d) begin
        dk_q    <= d2_kind_q;
        dop_q   <= d2_op_q;
        dopnd_q <= d2_opnd_q;
        dpc_q   <= d2_pc_q;
        dtgt_q  <= tgt_d;
      end
    end
  end

  assign disp_valid    = dv_q;
  assign disp_kind     = dk_q;
  assign disp_opcode   = dop_q;
  assign disp_operands = dopnd_q;
  assign disp_pc       = dpc_q;
  assign disp_target   = dtgt_q;
endmodule

// File: rtl/bcd_dispatch_unit.sv
module bcd_dispatch_unit
  import bcd_pkg::*;
#(
  parameter int          EMU_SHIFT    = 4,
  parameter logic [31:0] UNDEF_VECTOR = 32'h0000_0100,
  parameter int          BUF_BYTES    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_we,
  input  logic [7:0]  tbl_idx,
  input  logic [3:0]  tbl_data,
  input  logic        enter_valid,
  input  logic        enter_cond,
  input  logic [31:0] enter_target,
  input  logic [31:0] native_pc,
  input  logic [31:0] emu_base,
  input  logic        irq,
  output logic        imem_req,
  output logic [31:0] imem_addr,
  input  logic        imem_rvalid,
  input  logic [31:0] imem_rdata,
  output logic        bc_state,
  output logic        saved_bc_state,
  output logic [31:0] link_pc,
  output logic [31:0] exit_pc,
  output logic        disp_valid,
  output logic [1:0]  disp_kind,
  output logic [7:0]  disp_opcode,
  output logic [23:0] disp_operands,
  output logic [31:0] disp_pc,
  output logic [31:0] disp_target
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  logic             st_q, st_d, sv_q, sv_d;
  logic [31:0]      link_q, link_d, xpc_q, xpc_d;
  logic             start, leave, run, exit_now, consume;
  logic [2:0]       take_len;
  logic [31:0]      head_pc, window, restart_pc;
  logic [CNT_W-1:0] count;
  logic [OP_W-1:0]  look_op;
  tbl_entry_t       entry;

  assign start = enter_valid && enter_cond && !st_q;
  assign leave = st_q && (irq || exit_now);
  assign run   = st_q && !leave;

  always_comb begin
    st_d   = st_q;
    sv_d   = sv_q;
    link_d = link_q;
    xpc_d  = xpc_q;
    if (start) begin
      st_d   = 1'b1;
      link_d = native_pc;
    end else if (leave) begin
      st_d  = 1'b0;
      xpc_d = restart_pc;
    end
    if (irq) sv_d = st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= 1'b0;
      sv_q   <= 1'b0;
      link_q <= '0;
      xpc_q  <= '0;
    end else begin
      st_q   <= st_d;
      sv_q   <= sv_d;
      link_q <= link_d;
      xpc_q  <= xpc_d;
    end
  end

  bcd_class_table #(.ENTRIES(256)) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we && !st_q),
    .wr_idx  (tbl_idx),
    .wr_data (tbl_entry_t'(tbl_data)),
    .rd_idx  (look_op),
    .rd_data (entry)
  );

  bcd_fetch_buf #(.BUF_BYTES(BUF_BYTES)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_pc (enter_target),
    .run      (run),
    .abort    (leave),
    .consume  (consume),
    .take_len (take_len),
    .rvalid   (imem_rvalid),
    .rdata    (imem_rdata),
    .req      (imem_req),
    .addr     (imem_addr),
    .head_pc  (head_pc),
    .window   (window),
    .count    (count)
  );

  bcd_decode #(
    .EMU_SHIFT    (EMU_SHIFT),
    .UNDEF_VECTOR (UNDEF_VECTOR),
    .CNT_W        (CNT_W)
  ) u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (st_q),
    .irq           (irq),
    .window        (window),
    .count         (count),
    .head_pc       (head_pc),
    .entry         (entry),
    .emu_base      (emu_base),
    .look_op       (look_op),
    .consume       (consume),
    .take_len      (take_len),
    .exit_now      (exit_now),
    .restart_pc    (restart_pc),
    .disp_valid    (disp_valid),
    .disp_kind     (disp_kind),
    .disp_opcode   (disp_opcode),
    .disp_operands (disp_operands),
    .disp_pc       (disp_pc),
    .disp_target   (disp_target)
  );

  assign bc_state       = st_q;
  assign saved_bc_state = sv_q;
  assign link_pc        = link_q;
  assign exit_pc        = xpc_q;
endmodule

// File: rtl/bcd_unit_checker.sv
module bcd_unit_checker #(
  parameter int          EMU_SHIFT    = 4,
  parameter logic [31:0] UNDEF_VECTOR = 32'h0000_0100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        enter_valid,
  input logic        enter_cond,
  input logic [31:0] native_pc,
  input logic [31:0] emu_base,
  input logic        irq,
  input logic        imem_req,
  input logic [31:0] imem_addr,
  input logic        bc_state,
  input logic        saved_bc_state,
  input logic [31:0] link_pc,
  input logic [31:0] exit_pc,
  input logic        disp_valid,
  input logic [1:0]  disp_kind,
  input logic [7:0]  disp_opcode,
  input logic [31:0] disp_pc,
  input logic [31:0] disp_target
);
  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |-> imem_addr[1:0] == 2'b00); // R3
  AST_NO_FETCH_NATIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_state |-> !imem_req); // R3
  AST_ENTER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!bc_state && enter_valid && enter_cond) |=> (bc_state && link_pc == $past(native_pc))); // R2
  AST_ENTER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!bc_state && enter_valid && !enter_cond) |=> !bc_state); // R2
  AST_IRQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_state && irq) |=> (!bc_state && !disp_valid && saved_bc_state)); // R8
  AST_NONHW_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_kind != 2'b01) |-> (!bc_state && exit_pc == disp_pc)); // R6
  AST_EMU_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_kind == 2'b10) |->
      disp_target == $past(emu_base) + ({24'b0, disp_opcode} << EMU_SHIFT)); // R6
  AST_UNDEF_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_kind == 2'b00) |-> disp_target == UNDEF_VECTOR); // R7
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_kind != 2'b11); // R7
endmodule

bind bcd_dispatch_unit bcd_unit_checker #(
  .EMU_SHIFT    (EMU_SHIFT),
  .UNDEF_VECTOR (UNDEF_VECTOR)
) u_chk (.*);

// File: tb/bcd_dispatch_unit_test.sv
`timescale 1ns/1ps
module bcd_dispatch_unit_test;
  localparam int          SHIFT   = 4;
  localparam logic [31:0] UVEC    = 32'h0000_0100;
  localparam logic [31:0] EBASE   = 32'h0001_0000;
  localparam int          PSIZE   = 1024;
  localparam int          CAPN    = 8192;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we, enter_valid, enter_cond, irq, imem_rvalid;
  logic [7:0]  tbl_idx;
  logic [3:0]  tbl_data;
  logic [31:0] enter_target, native_pc, emu_base, imem_rdata;
  logic        imem_req, bc_state, saved_bc_state, disp_valid;
  logic [31:0] imem_addr, link_pc, exit_pc, disp_pc, disp_target;
  logic [1:0]  disp_kind;
  logic [7:0]  disp_opcode;
  logic [23:0] disp_operands;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0]  prog [PSIZE];
  logic [1:0]  cap_kind [CAPN];
  logic [7:0]  cap_op [CAPN];
  logic [23:0] cap_opnd [CAPN];
  logic [31:0] cap_pc [CAPN];
  logic [31:0] cap_tgt [CAPN];
  int          cap_n = 0;
  logic        m_pend = 1'b0;
  logic [31:0] m_addr = '0;

  always #4 clk = ~clk;

  bcd_dispatch_unit #(.EMU_SHIFT(SHIFT), .UNDEF_VECTOR(UVEC)) uut (.*);

  function automatic logic [3:0] ref_entry(input logic [7:0] op);
    logic [1:0] c;
    if (op < 8'hC0)      c = 2'b01;
    else if (op < 8'hE8) c = 2'b10;
    else if (op < 8'hF4) c = 2'b00;
    else                 c = 2'b11;
    return {c, op[1:0]};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[i*8 +: 8] = prog[(int'(a[9:0]) + i) % PSIZE];
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // instruction memory model: one-cycle response per request
  initial begin
    imem_rvalid = 1'b0;
    imem_rdata  = '0;
    forever begin
      @(negedge clk);
      #2;
      imem_rvalid = m_pend;
      imem_rdata  = mem_word(m_addr);
      m_pend      = imem_req;
      m_addr      = imem_addr;
    end
  end

  // dispatch monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && disp_valid && cap_n < CAPN) begin
        cap_kind[cap_n] = disp_kind;
        cap_op[cap_n]   = disp_opcode;
        cap_opnd[cap_n] = disp_operands;
        cap_pc[cap_n]   = disp_pc;
        cap_tgt[cap_n]  = disp_target;
        cap_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic run_seg(input logic [31:0] tgt, input int irq_at, input bit poke,
                         output logic [31:0] resume_pc, output int ndisp);
    int          first, cyc;
    logic [31:0] epc, npc, etgt;
    logic [7:0]  op;
    logic [3:0]  ent;
    logic [23:0] eopnd;
    logic [1:0]  ekind;
    bit          nonhw_end;
    @(negedge clk);
    npc          = tgt ^ 32'h4000_0000;
    enter_valid  = 1'b1;
    enter_cond   = 1'b1;
    enter_target = tgt;
    native_pc    = npc;
    first        = cap_n;
    @(negedge clk);
    enter_valid = 1'b0;
    check(bc_state == 1'b1, "R2 state bit after entry", 32'(bc_state), 32'd1);
    check(link_pc == npc, "R2 link pc", link_pc, npc);
    if (poke) begin
      tbl_we   = 1'b1;
      tbl_idx  = 8'h08;
      tbl_data = 4'b0000;
    end
    cyc = 0;
    while (bc_state && cyc < 400) begin
      @(negedge clk);
      tbl_we = 1'b0;
      irq    = 1'b0;
      cyc++;
      if ((cyc == irq_at || cyc == 300) && bc_state) irq = 1'b1;
    end
    @(negedge clk);
    irq = 1'b0;
    repeat (4) @(negedge clk);
    epc       = tgt;
    nonhw_end = 1'b0;
    for (int k = first; k < cap_n; k++) begin
      op    = prog[int'(epc[9:0])];
      ent   = ref_entry(op);
      eopnd = '0;
      for (int b = 1; b <= 3; b++)
        if (b <= int'(ent[1:0])) eopnd[(b-1)*8 +: 8] = prog[(int'(epc[9:0]) + b) % PSIZE];
      ekind = (ent[3:2] == 2'b01) ? 2'b01 : (ent[3:2] == 2'b10) ? 2'b10 : 2'b00;
      etgt  = (ekind == 2'b01) ? 32'd0 :
              (ekind == 2'b10) ? EBASE + (32'(op) << SHIFT) : UVEC;
      check(cap_pc[k] == epc, "R4 dispatch pc", cap_pc[k], epc);
      check(cap_op[k] == op, "R4 opcode", 32'(cap_op[k]), 32'(op));
      check(cap_opnd[k] == eopnd, "R4 operands", 32'(cap_opnd[k]), 32'(eopnd));
      if (ekind == 2'b01) begin
        check(cap_kind[k] == ekind && cap_tgt[k] == etgt, "R5 hardware kind/target",
              {cap_kind[k], cap_tgt[k][29:0]}, {ekind, etgt[29:0]});
        epc = epc + 32'(ent[1:0]) + 32'd1;
      end else begin
        check(cap_kind[k] == ekind && cap_tgt[k] == etgt,
              (ekind == 2'b10) ? "R6 emulated kind/target" : "R7 undefined kind/target",
              cap_tgt[k], etgt);
        check(k == cap_n - 1, "R6 no dispatch after leaving", 32'(cap_n - 1 - k), 32'd0);
        nonhw_end = 1'b1;
      end
    end
    check(bc_state == 1'b0, "R8 state bit low after exit", 32'(bc_state), 32'd0);
    if (nonhw_end) begin
      check(exit_pc == epc, "R6 return point", exit_pc, epc);
    end else begin
      check(exit_pc == epc, "R8 restart pc", exit_pc, epc);
      check(saved_bc_state == 1'b1, "R8 saved state flag", 32'(saved_bc_state), 32'd1);
    end
    resume_pc = epc;
    ndisp     = cap_n - first;
  endtask

  initial begin
    logic [31:0] rpc, nxt;
    int          nd, pos, r;
    void'($urandom(32'd7391));
    rst_n = 1'b0; tbl_we = 1'b0; tbl_idx = '0; tbl_data = '0;
    enter_valid = 1'b0; enter_cond = 1'b0; enter_target = '0; native_pc = '0;
    emu_base = EBASE; irq = 1'b0;
    pos = 0;
    while (pos < PSIZE) begin
      r = int'($urandom % 100);
      if (r < 92)      prog[pos] = 8'($urandom % 192);
      else if (r < 96) prog[pos] = 8'(8'hC0 + $urandom % 40);
      else             prog[pos] = 8'(8'hE8 + $urandom % 24);
      nd = int'(prog[pos][1:0]);
      pos++;
      for (int b = 0; b < nd; b++) if (pos < PSIZE) begin prog[pos] = 8'($urandom); pos++; end
    end
    prog[10'h300] = 8'h05; prog[10'h301] = 8'hAA;
    prog[10'h302] = 8'h13; prog[10'h303] = 8'h11; prog[10'h304] = 8'h22; prog[10'h305] = 8'h33;
    prog[10'h306] = 8'h08; prog[10'h307] = 8'hC5; prog[10'h308] = 8'h77;
    prog[10'h310] = 8'hF6;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bc_state == 1'b0, "R1 reset state bit", 32'(bc_state), 32'd0);
    check(disp_valid == 1'b0, "R1 reset dispatch", 32'(disp_valid), 32'd0);
    check(imem_req == 1'b0, "R1 reset fetch", 32'(imem_req), 32'd0);
    check(saved_bc_state == 1'b0, "R1 reset saved flag", 32'(saved_bc_state), 32'd0);

    for (int i = 0; i < 256; i++) begin
      tbl_we = 1'b1; tbl_idx = 8'(i); tbl_data = ref_entry(8'(i));
      @(negedge clk);
    end
    tbl_we = 1'b0;

    // failed condition: no entry
    enter_valid = 1'b1; enter_cond = 1'b0; enter_target = 32'h40; native_pc = 32'h1234;
    @(negedge clk);
    enter_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(bc_state == 1'b0, "R2 refused entry", 32'(bc_state), 32'd0);
    check(imem_req == 1'b0, "R2 no fetch after refused entry", 32'(imem_req), 32'd0);

    // unaligned entry, word-crossing bytecode, ignored table write (R9)
    run_seg(32'h302, -1, 1'b1, rpc, nd);
    check(nd == 3, "R9 table write during state ignored", 32'(nd), 32'd3);
    run_seg(32'h310, -1, 1'b0, rpc, nd);
    check(nd == 1, "R7 undefined class 11 at entry", 32'(nd), 32'd1);

    // interrupt early, then interrupt in native state
    run_seg(32'h21, 3, 1'b0, rpc, nd);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    check(saved_bc_state == 1'b0, "R8 native interrupt clears flag", 32'(saved_bc_state), 32'd0);
    run_seg(rpc, -1, 1'b0, rpc, nd);

    nxt = 32'h0;
    for (int s = 0; s < 40; s++) begin
      run_seg(nxt, ($urandom % 2 == 0) ? int'(2 + $urandom % 40) : -1, 1'b0, rpc, nd);
      nxt = ($urandom % 2 == 0) ? rpc + 32'd0 : 32'($urandom % PSIZE);
      if (cap_n > 0 && cap_kind[cap_n-1] != 2'b01 && nxt == rpc)
        nxt = 32'($urandom % PSIZE);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule